// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns the operands of a single-word load or store into the address the memory access uses. It also produces the value the base register should take afterwards, and a flag that says whether that value must be written back. It takes a base value and an offset. The offset is either an immediate or a second register value shifted left by a 0–31 bit amount. The block adds the offset to the base or subtracts it, with wrap-around. Three indexing styles are supported. Plain offset addresses base±offset and leaves the base alone. Pre-indexed addresses base±offset and writes that sum back. Post-indexed addresses with the untouched base and writes base±offset back.

The arithmetic is combinational. Its results are captured in output registers on the clock edge where `in_valid` is high, so every result appears one cycle after its request. The block does no memory access, no register file access and no decode.

Top module: `ls_agu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `out_valid`=0, `wb_en`=0, `addr`=0 and `new_base`=0.
- R2: Plain offset mode (`mode`=2'b00): `addr` = base ± offset, `new_base` = base, `wb_en`=0.
- R3: Pre-indexed mode (`mode`=2'b01): `addr` = `new_base` = base ± offset, `wb_en`=1.
- R4: Post-indexed mode (`mode`=2'b10): `addr` = base, `new_base` = base ± offset, `wb_en`=1.
- R5: With `use_reg`=0 the offset is `imm` unshifted, and `shamt` has no effect. With `use_reg`=1 the offset is `idx` shifted left by `shamt`.
- R6: The shift accepts every amount from 0 to 31. Bits shifted past bit 31 are discarded, and zeros fill from the right.
- R7: `sub`=1 subtracts the offset from the base and `sub`=0 adds it. Both results wrap modulo 2^32.
- R8: `mode`=2'b11 behaves exactly like plain offset mode, with no writeback.
- R9: Results appear on the outputs one cycle after a rising edge with `in_valid`=1, and `out_valid` is high in that cycle. After an edge with `in_valid`=0, `out_valid` and `wb_en` are 0 and `addr` and `new_base` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| imm | input | 32 | Immediate offset |
| idx | input | 32 | Index register value |
| use_reg | input | 1 | 1 selects shifted index, 0 selects immediate |
| shamt | input | 5 | Left-shift amount for the index |
| sub | input | 1 | 1 subtracts the offset, 0 adds it |
| mode | input | 2 | 00 plain, 01 pre-indexed, 10 post-indexed, 11 as plain |
| out_valid | output | 1 | Registered result valid |
| addr | output | 32 | Access address |
| new_base | output | 32 | Base value after the access |
| wb_en | output | 1 | Base writeback required |

## Verification
A wrong offset source, a wrong shift or a flipped add/subtract select shows up as a wrong `addr` or `new_base`. It appears exactly one cycle after the request, so every directed vector is compared in that cycle. A mode decode error shows as `addr` and `new_base` swapped or equal when they should not be, or as a wrong `wb_en`. Stale or leaking register state shows as `out_valid`/`wb_en` staying high, or as the outputs changing, on an idle cycle that follows a request.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  typedef enum logic [1:0] {
    IDX_PLAIN = 2'b00,
    IDX_PRE   = 2'b01,
    IDX_POST  = 2'b10,
    IDX_RSVD  = 2'b11
  } idx_mode_e;
endpackage

// File: rtl/ls_agu_offset.sv
module ls_agu_offset #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] idx,
  input  logic              use_reg,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] offset
);
  logic [DATA_W-1:0] scaled;
  always_comb begin
    scaled = idx << shamt;
    offset = use_reg ? scaled : imm;
  end
endmodule

// File: rtl/ls_agu_addsub.sv
module ls_agu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              sub,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    if (sub) result = base - offset;
    else     result = base + offset;
  end
endmodule

// File: rtl/ls_agu_select.sv
module ls_agu_select
  import ls_agu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] addr_d,
  output logic [DATA_W-1:0] base_d,
  output logic              wb_d
);
  idx_mode_e m;
  always_comb begin
    m = idx_mode_e'(mode);
    case (m)
      IDX_PRE: begin
        addr_d = sum;
        base_d = sum;
        wb_d   = 1'b1;
      end
      IDX_POST: begin
        addr_d = base;
        base_d = sum;
        wb_d   = 1'b1;
      end
      default: begin
        addr_d = sum;
        base_d = base;
        wb_d   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] idx,
  input  logic              use_reg,
  input  logic [SH_W-1:0]   shamt,
  input  logic              sub,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] new_base,
  output logic              wb_en
);
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] addr_d;
  logic [DATA_W-1:0] base_d;
  logic              wb_d;

  ls_agu_offset #(.DATA_W(DATA_W)) u_offset (
    .imm(imm), .idx(idx), .use_reg(use_reg), .shamt(shamt), .offset(offset)
  );

  ls_agu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .base(base), .offset(offset), .sub(sub), .result(sum)
  );

  ls_agu_select #(.DATA_W(DATA_W)) u_select (
    .mode(mode), .base(base), .sum(sum),
    .addr_d(addr_d), .base_d(base_d), .wb_d(wb_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      addr      <= '0;
      new_base  <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & wb_d;
      if (in_valid) begin
        addr     <= addr_d;
        new_base <= base_d;
      end
    end
  end
endmodule

// File: rtl/ls_agu_chk.sv
module ls_agu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] base,
  input logic [1:0]        mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] addr,
  input logic [DATA_W-1:0] new_base,
  input logic              wb_en
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !wb_en && addr == '0 && new_base == '0));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wb_en && $stable(addr) && $stable(new_base)));

  // R2
  plain_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00) |=> (!wb_en && new_base == $past(base)));

  // R3
  pre_same_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01) |=> (wb_en && addr == new_base));

  // R4
  post_base_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b10) |=> (wb_en && addr == $past(base)));

  // R8
  rsvd_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b11) |=> (!wb_en && new_base == $past(base)));
endmodule

bind ls_agu ls_agu_chk #(.DATA_W(DATA_W)) u_ls_agu_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .mode(mode),
  .out_valid(out_valid), .addr(addr), .new_base(new_base), .wb_en(wb_en)
);

// File: tb/test_ls_agu.sv
`timescale 1ns/1ps
module test_ls_agu;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] base, imm, idx;
  logic        use_reg;
  logic [4:0]  shamt;
  logic        sub;
  logic [1:0]  mode;
  logic        out_valid;
  logic [31:0] addr, new_base;
  logic        wb_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ls_agu i_ls_agu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .imm(imm),
    .idx(idx), .use_reg(use_reg), .shamt(shamt), .sub(sub), .mode(mode),
    .out_valid(out_valid), .addr(addr), .new_base(new_base), .wb_en(wb_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Issue one request, wait one edge, compare at the following negedge.
  task automatic run(input string req, input logic [1:0] m,
                     input logic [31:0] b, input logic [31:0] im,
                     input logic [31:0] ix, input logic ur,
                     input logic [4:0] sh, input logic sb);
    logic [31:0] off, s, ea, eb;
    logic ew;
    off = ur ? (ix << sh) : im;
    s   = sb ? (b - off) : (b + off);
    case (m)
      2'b01:   begin ea = s; eb = s; ew = 1'b1; end
      2'b10:   begin ea = b; eb = s; ew = 1'b1; end
      default: begin ea = s; eb = b; ew = 1'b0; end
    endcase
    in_valid = 1'b1; mode = m; base = b; imm = im; idx = ix;
    use_reg = ur; shamt = sh; sub = sb;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", {31'b0, out_valid}, 32'd1);
    chk(req, "addr", addr, ea);
    chk(req, "new_base", new_base, eb);
    chk(req, "wb_en", {31'b0, wb_en}, {31'b0, ew});
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1; base = 32'hDEAD_BEEF; imm = 32'h10;
    idx = 0; use_reg = 0; shamt = 0; sub = 0; mode = 2'b01;
    repeat (2) @(negedge clk);
    chk("R1", "out_valid", {31'b0, out_valid}, 0);
    chk("R1", "wb_en", {31'b0, wb_en}, 0);
    chk("R1", "addr", addr, 0);
    chk("R1", "new_base", new_base, 0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_plain;
    run("R2", 2'b00, 32'h0000_1000, 32'h2, 0, 0, 0, 0);
    run("R2", 2'b00, 32'h8000_0000, 0, 32'h3, 1, 5'd4, 0);
  endtask

  task automatic t_pre;
    run("R3", 2'b01, 32'h0000_2000, 32'h4, 0, 0, 0, 0);
    run("R3", 2'b01, 32'h0000_2000, 0, 32'h5, 1, 5'd2, 0);
  endtask

  task automatic t_post;
    run("R4", 2'b10, 32'h0000_3000, 32'h4, 0, 0, 0, 0);
    run("R4", 2'b10, 32'h0000_3000, 0, 32'h7, 1, 5'd2, 1);
  endtask

  task automatic t_source;
    // R5: immediate path ignores a nonzero shamt
    run("R5", 2'b00, 32'h100, 32'h3, 32'hFFFF, 0, 5'd7, 0);
    run("R5", 2'b01, 32'h100, 32'hFFFF, 32'h3, 1, 5'd1, 0);
  endtask

  task automatic t_shift;
    run("R6", 2'b00, 0, 0, 32'h1, 1, 5'd0, 0);
    run("R6", 2'b00, 0, 0, 32'h1, 1, 5'd31, 0);
    run("R6", 2'b10, 32'h10, 0, 32'hF000_000F, 1, 5'd30, 0);
  endtask

  task automatic t_sub;
    run("R7", 2'b01, 32'h0000_0010, 32'h20, 0, 0, 0, 1);
    run("R7", 2'b00, 32'hFFFF_FFF0, 32'h20, 0, 0, 0, 0);
    run("R7", 2'b10, 32'h100, 0, 32'h4, 1, 5'd3, 1);
  endtask

  task automatic t_rsvd;
    run("R8", 2'b11, 32'h4000, 32'h8, 0, 0, 0, 0);
    run("R8", 2'b11, 32'h4000, 0, 32'h2, 1, 5'd2, 1);
  endtask

  task automatic t_idle;
    logic [31:0] a0, b0;
    run("R9", 2'b01, 32'h5000, 32'h40, 0, 0, 0, 0);
    a0 = addr; b0 = new_base;
    base = 32'h1234_5678; imm = 32'h99; mode = 2'b01;
    @(negedge clk);
    chk("R9", "idle out_valid", {31'b0, out_valid}, 0);
    chk("R9", "idle wb_en", {31'b0, wb_en}, 0);
    chk("R9", "idle addr", addr, a0);
    chk("R9", "idle new_base", new_base, b0);
    // back-to-back requests
    run("R9", 2'b10, 32'h600, 32'h8, 0, 0, 0, 0);
    run("R9", 2'b00, 32'h700, 32'h8, 0, 0, 0, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_plain;
    t_pre;
    t_post;
    t_source;
    t_shift;
    t_sub;
    t_rsvd;
    t_idle;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule